// File: doc/BRIEF.md
# Segment Descriptor Translation Unit

This block turns a selector-plus-offset reference into a linear address. It keeps a small set of segment slots. Loading a 16-bit selector into a slot starts a single descriptor read. The read address comes from the selector's index and its table bit, added to one of two table base inputs. The returned descriptor is decoded into a base, a limit and a segment kind, and cached in the slot. Later accesses to that slot use only the cached copy.

Each access names a slot, an offset and a kind (read, write or instruction fetch). The block checks the access against the cached segment kind and the offset against the cached limit. It then returns, one cycle later, either `base + offset` or a fault code. While a slot's descriptor read is outstanding, accesses to that slot are held off with a stall. Accesses to other slots proceed. A descriptor whose present flag is clear is reported when the read completes, and it leaves the slot unusable.

Top module: `seg_xlate_unit`

## Requirements
- R1: The descriptor read address is `sel[15:3] * 8` plus the table base chosen by selector bit 2: `glb_tbl_base` when bit 2 is 0, `loc_tbl_base` when bit 2 is 1.
- R2: Each accepted selector load makes exactly one descriptor read handshake (`rd_valid && rd_ready`). Accesses never cause a read.
- R3: `rd_valid` and `rd_addr` hold steady until `rd_ready`. `ld_ready` is low from the accepted load until the cycle after the response, so only one load is in flight.
- R4: While a slot's descriptor read is outstanding, `acc_stall` is high for an access naming that slot and low for an access naming any other slot.
- R5: An accepted access (`acc_valid && !acc_stall`) gives `res_valid` on the next cycle. With fault code 0 the result is `res_addr = base + acc_off`, where the descriptor fields are base = `rsp_data[31:0]`, limit = `rsp_data[51:32]` (byte granular), kind = `rsp_data[53:52]` and present = `rsp_data[63]`. The remaining bits are ignored.
- R6: An offset greater than the cached limit gives fault code 1 and `res_addr = 0`. An offset equal to the limit is translated.
- R7: The kind codes are 0 = read/write data, 1 = read-only data, 2 = execute-only code and 3 = execute/read code. The access codes are 0 = read, 1 = write and 2 = fetch. A write to kinds 1 to 3, a read from kind 2, or a fetch from kind 0 or 1 gives fault code 2 and `res_addr = 0`.
- R8: A response with the present bit clear gives `ld_done = 1` with `ld_np = 1` in the cycle after the response. It leaves the slot invalid. An access to an invalid slot, including any slot never loaded since reset, gives fault code 3.
- R9: Selector bits 1:0 of the loaded selector appear on `res_rpl` for every result from that slot. They are not checked.
- R10: Fault priority is invalid slot (3) over rights (2) over limit (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_tbl_base | input | 32 | Base address of the global descriptor table |
| loc_tbl_base | input | 32 | Base address of the local descriptor table |
| ld_valid | input | 1 | Selector load request |
| ld_seg | input | 2 | Slot being loaded |
| ld_sel | input | 16 | Selector value |
| ld_ready | output | 1 | Load can be accepted |
| ld_done | output | 1 | Descriptor load finished (one-cycle pulse) |
| ld_np | output | 1 | Finished load found the descriptor not present |
| rd_valid | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor read address |
| rd_ready | input | 1 | Read request taken |
| rsp_valid | input | 1 | Descriptor data returned |
| rsp_data | input | 64 | Descriptor contents |
| acc_valid | input | 1 | Access request |
| acc_seg | input | 2 | Slot used by the access |
| acc_off | input | 32 | Offset within the segment |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch |
| acc_stall | output | 1 | Access held off, slot fetch outstanding |
| res_valid | output | 1 | Result valid |
| res_addr | output | 32 | Linear address (0 on fault) |
| res_fault | output | 2 | 0 none, 1 limit, 2 rights, 3 invalid slot |
| res_rpl | output | 2 | Requested privilege bits of the slot's selector |

## Verification
Assertions check on every cycle that a read request holds its address until taken, and that a stall only appears while a read is outstanding. They also check that a faulted result never carries an address, that every result follows an accepted access by one cycle, and that a not-present completion leaves its slot invalid. Address arithmetic, the choice of table, the kind-versus-access matrix, the boundary at offset equal to limit, fault priority and the count of reads per load are shown only by the bench's directed and seeded random scenarios against its own model of the slots.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W = 32;
  localparam int LIM_W  = 20;
  localparam int SEL_W  = 16;
  localparam int DESC_W = 64;
  localparam int IDX_LSB = 3;
  localparam int TI_BIT  = 2;
  localparam int D_BASE_LSB = 0;
  localparam int D_LIM_LSB  = 32;
  localparam int D_KIND_LSB = 52;
  localparam int D_PRES_BIT = 63;

  typedef enum logic [1:0] {K_RW = 2'd0, K_RO = 2'd1, K_XO = 2'd2, K_XR = 2'd3} seg_kind_t;
  typedef enum logic [1:0] {A_RD = 2'd0, A_WR = 2'd1, A_FX = 2'd2} acc_kind_t;
  typedef enum logic [1:0] {F_NONE = 2'd0, F_LIMIT = 2'd1, F_PROT = 2'd2, F_INVAL = 2'd3} fault_t;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    seg_kind_t         kind;
    logic [1:0]        rpl;
  } slot_t;

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [SEL_W-1:0] sel,
      input logic [ADDR_W-1:0] gbase, input logic [ADDR_W-1:0] lbase);
    logic [ADDR_W-1:0] tbl;
    logic [ADDR_W-1:0] idx;
    tbl = sel[TI_BIT] ? lbase : gbase;
    idx = ADDR_W'(sel[SEL_W-1:IDX_LSB]);
    return tbl + (idx << 3);
  endfunction

  function automatic slot_t decode_desc(input logic [DESC_W-1:0] d, input logic [1:0] rpl);
    slot_t s;
    s.base  = d[D_BASE_LSB +: ADDR_W];
    s.limit = d[D_LIM_LSB +: LIM_W];
    s.kind  = seg_kind_t'(d[D_KIND_LSB +: 2]);
    s.rpl   = rpl;
    return s;
  endfunction

  function automatic logic rights_ok(input seg_kind_t k, input logic [1:0] a);
    case (a)
      A_RD:    return k != K_XO;
      A_WR:    return k == K_RW;
      A_FX:    return (k == K_XO) || (k == K_XR);
      default: return 1'b0;
    endcase
  endfunction

  function automatic fault_t classify(input logic vld, input slot_t s,
      input logic [ADDR_W-1:0] off, input logic [1:0] a);
    if (!vld)                           return F_INVAL;
    if (!rights_ok(s.kind, a))          return F_PROT;
    if (off > ADDR_W'(s.limit))         return F_LIMIT;
    return F_NONE;
  endfunction
endpackage

// File: rtl/seg_fetch.sv
module seg_fetch
  import seg_pkg::*;
#(
  parameter int SEG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] glb_tbl_base,
  input  logic [ADDR_W-1:0] loc_tbl_base,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [SEL_W-1:0]  ld_sel,
  output logic              ld_ready,
  output logic              ld_done,
  output logic              ld_np,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [DESC_W-1:0] rsp_data,
  output logic              busy,
  output logic [SEG_W-1:0]  pend_seg,
  output logic              fill_en,
  output logic              fill_present,
  output slot_t             fill_slot
);
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} st_t;
  st_t        st;
  logic [1:0] pend_rpl;

  assign busy         = st != ST_IDLE;
  assign ld_ready     = !busy;
  assign rd_valid     = st == ST_REQ;
  assign fill_en      = (st == ST_WAIT) && rsp_valid;
  assign fill_present = rsp_data[D_PRES_BIT];
  assign fill_slot    = decode_desc(rsp_data, pend_rpl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      rd_addr  <= '0;
      pend_seg <= '0;
      pend_rpl <= '0;
      ld_done  <= 1'b0;
      ld_np    <= 1'b0;
    end else begin
      ld_done <= fill_en;
      ld_np   <= fill_en && !fill_present;
      case (st)
        ST_IDLE: if (ld_valid) begin
          st       <= ST_REQ;
          rd_addr  <= desc_addr(ld_sel, glb_tbl_base, loc_tbl_base);
          pend_seg <= ld_seg;
          pend_rpl <= ld_sel[1:0];
        end
        ST_REQ:  if (rd_ready)  st <= ST_WAIT;
        ST_WAIT: if (rsp_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr)); // R3
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done |-> $past(rsp_valid)); // R2
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEG_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr_en,
  input  logic [SEG_W-1:0]          clr_seg,
  input  logic                      fill_en,
  input  logic [SEG_W-1:0]          fill_seg,
  input  logic                      fill_present,
  input  slot_t                     fill_slot,
  output logic [NSEG-1:0]           slot_vld,
  output slot_t [NSEG-1:0]          slots
);
  for (genvar g = 0; g < NSEG; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[g] <= 1'b0;
        slots[g]    <= '0;
      end else if (clr_en && clr_seg == SEG_W'(g)) begin
        slot_vld[g] <= 1'b0;
      end else if (fill_en && fill_seg == SEG_W'(g)) begin
        slot_vld[g] <= fill_present;
        if (fill_present) slots[g] <= fill_slot;
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_pkg::*;
#(
  parameter int NSEG  = 4,
  parameter int SEG_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSEG-1:0]   slot_vld,
  input  slot_t [NSEG-1:0]  slots,
  input  logic              busy,
  input  logic [SEG_W-1:0]  pend_seg,
  input  logic              acc_valid,
  input  logic [SEG_W-1:0]  acc_seg,
  input  logic [ADDR_W-1:0] acc_off,
  input  logic [1:0]        acc_kind,
  output logic              acc_stall,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic [1:0]        res_fault,
  output logic [1:0]        res_rpl
);
  slot_t  cur;
  fault_t flt;
  logic   take;

  assign cur       = slots[acc_seg];
  assign acc_stall = acc_valid && busy && (pend_seg == acc_seg);
  assign take      = acc_valid && !acc_stall;
  assign flt       = classify(slot_vld[acc_seg], cur, acc_off, acc_kind);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_fault <= '0;
      res_rpl   <= '0;
    end else begin
      res_valid <= take;
      if (take) begin
        res_fault <= flt;
        res_rpl   <= cur.rpl;
        res_addr  <= (flt == F_NONE) ? cur.base + acc_off : '0;
      end
    end
  end

  AST_STALL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stall |-> busy); // R4
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault != 2'd0 |-> res_addr == '0); // R6
  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(acc_valid && !acc_stall)); // R5
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_pkg::*;
#(
  parameter int NSEG  = 4,
  localparam int SEG_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       glb_tbl_base,
  input  logic [31:0]       loc_tbl_base,
  input  logic              ld_valid,
  input  logic [SEG_W-1:0]  ld_seg,
  input  logic [15:0]       ld_sel,
  output logic              ld_ready,
  output logic              ld_done,
  output logic              ld_np,
  output logic              rd_valid,
  output logic [31:0]       rd_addr,
  input  logic              rd_ready,
  input  logic              rsp_valid,
  input  logic [63:0]       rsp_data,
  input  logic              acc_valid,
  input  logic [SEG_W-1:0]  acc_seg,
  input  logic [31:0]       acc_off,
  input  logic [1:0]        acc_kind,
  output logic              acc_stall,
  output logic              res_valid,
  output logic [31:0]       res_addr,
  output logic [1:0]        res_fault,
  output logic [1:0]        res_rpl
);
  logic             busy, fill_en, fill_present, load_take;
  logic [SEG_W-1:0] pend_seg;
  slot_t            fill_slot;
  logic [NSEG-1:0]  slot_vld;
  slot_t [NSEG-1:0] slots;

  assign load_take = ld_valid && ld_ready;

  seg_fetch #(.SEG_W(SEG_W)) fetch_i (
    .clk, .rst_n, .glb_tbl_base, .loc_tbl_base, .ld_valid, .ld_seg, .ld_sel,
    .ld_ready, .ld_done, .ld_np, .rd_valid, .rd_addr, .rd_ready, .rsp_valid,
    .rsp_data, .busy, .pend_seg, .fill_en, .fill_present, .fill_slot);

  seg_cache #(.NSEG(NSEG), .SEG_W(SEG_W)) cache_i (
    .clk, .rst_n, .clr_en(load_take), .clr_seg(ld_seg), .fill_en,
    .fill_seg(pend_seg), .fill_present, .fill_slot, .slot_vld, .slots);

  seg_check #(.NSEG(NSEG), .SEG_W(SEG_W)) check_i (
    .clk, .rst_n, .slot_vld, .slots, .busy, .pend_seg, .acc_valid, .acc_seg,
    .acc_off, .acc_kind, .acc_stall, .res_valid, .res_addr, .res_fault, .res_rpl);

  AST_NP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
    ld_done && ld_np |-> !slot_vld[pend_seg]); // R8
  AST_LOAD_DURING_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !ld_ready); // R3
endmodule

// File: tb/seg_xlate_unit_tb_top.sv
module seg_xlate_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] glb_tbl_base = 32'h0010_0000, loc_tbl_base = 32'h0A00_0000;
  logic        ld_valid = 0;
  logic [1:0]  ld_seg = 0;
  logic [15:0] ld_sel = 0;
  logic        ld_ready, ld_done, ld_np, rd_valid;
  logic [31:0] rd_addr;
  logic        rd_ready = 0, rsp_valid = 0;
  logic [63:0] rsp_data = 0;
  logic        acc_valid = 0;
  logic [1:0]  acc_seg = 0;
  logic [31:0] acc_off = 0;
  logic [1:0]  acc_kind = 0;
  logic        acc_stall, res_valid;
  logic [31:0] res_addr;
  logic [1:0]  res_fault, res_rpl;

  always #10 clk = ~clk;

  seg_xlate_unit dut_i (.*);

  int n_chk = 0, n_bad = 0, n_rd = 0, n_loads = 0;
  logic        m_vld[4];
  logic [31:0] m_base[4];
  logic [19:0] m_lim[4];
  logic [1:0]  m_kind[4], m_rpl[4];

  always @(posedge clk) if (rst_n && rd_valid && rd_ready) n_rd++;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [15:0] s);
    logic [31:0] b;
    b = s[2] ? loc_tbl_base : glb_tbl_base;
    return b + {16'd0, s[15:3], 3'b000};
  endfunction

  function automatic logic [1:0] exp_flt(input int sg, input logic [31:0] off, input logic [1:0] a);
    logic allowed;
    if (!m_vld[sg]) return 2'd3;
    case (a)
      2'd0: allowed = m_kind[sg] != 2'd2;
      2'd1: allowed = m_kind[sg] == 2'd0;
      default: allowed = m_kind[sg][1];
    endcase
    if (!allowed) return 2'd2;
    if (off > {12'd0, m_lim[sg]}) return 2'd1;
    return 2'd0;
  endfunction

  task automatic load(input int sg, input logic [15:0] s, input logic [31:0] b,
                      input logic [19:0] lim, input logic [1:0] k, input logic pres);
    int other;
    other = (sg + 1) % 4;
    @(negedge clk);
    ld_valid = 1; ld_seg = 2'(sg); ld_sel = s;
    #1 chk("R3 ld_ready idle", ld_ready, 1);
    @(negedge clk);
    ld_valid = 0;
    n_loads++;
    chk("R1 rd_addr", rd_addr, exp_rd(s));
    chk("R3 rd_valid", rd_valid, 1);
    chk("R3 ld_ready busy", ld_ready, 0);
    acc_valid = 1; acc_seg = 2'(sg);
    #1 chk("R4 stall own slot", acc_stall, 1);
    acc_seg = 2'(other);
    #1 chk("R4 no stall other slot", acc_stall, 0);
    acc_valid = 0;
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk);
      chk("R3 rd held", {rd_valid, rd_addr}, {1'b1, exp_rd(s)});
    end
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    chk("R3 rd drop", rd_valid, 0);
    repeat ($urandom_range(0, 3)) @(negedge clk);
    rsp_valid = 1;
    rsp_data = {pres, 9'($urandom), k, lim, b};
    @(negedge clk);
    rsp_valid = 0;
    chk("R8 ld_done", {ld_done, ld_np}, {1'b1, !pres});
    chk("R3 ld_ready back", ld_ready, 1);
    m_vld[sg] = pres;
    if (pres) begin
      m_base[sg] = b; m_lim[sg] = lim; m_kind[sg] = k; m_rpl[sg] = s[1:0];
    end
  endtask

  task automatic access(input string req, input int sg, input logic [31:0] off, input logic [1:0] a);
    logic [1:0] f;
    f = exp_flt(sg, off, a);
    @(negedge clk);
    acc_valid = 1; acc_seg = 2'(sg); acc_off = off; acc_kind = a;
    #1 chk({req, " no stall"}, acc_stall, 0);
    @(negedge clk);
    acc_valid = 0;
    chk({req, " fault"}, {res_valid, res_fault}, {1'b1, f});
    chk({req, " addr R5"}, res_addr, f == 2'd0 ? m_base[sg] + off : 32'd0);
    if (m_vld[sg]) chk({req, " R9 rpl"}, res_rpl, m_rpl[sg]);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset ld_ready", ld_ready, 1);
    chk("reset rd_valid", rd_valid, 0);
    chk("reset res_valid/ld_done", {res_valid, ld_done}, 0);
    access("R8 never loaded", 0, 32'h10, 2'd0);
    access("R10 invalid beats limit", 1, 32'hFFFF_FFFF, 2'd1);
    // Directed: global table, read/write data, limit boundary (R1, R6)
    load(0, 16'h0013, 32'h0002_0000, 20'h00FFF, 2'd0, 1'b1);
    access("R6 off==limit", 0, 32'h0FFF, 2'd1);
    access("R6 off>limit", 0, 32'h1000, 2'd0);
    access("R7 fetch from data", 0, 32'h4, 2'd2);
    // Local table, maximum index, read-only (R1, R7, R10)
    load(1, 16'hFFFF, 32'h8000_0000, 20'h00010, 2'd1, 1'b1);
    access("R7 write read-only", 1, 32'h4, 2'd1);
    access("R10 prot beats limit", 1, 32'h100, 2'd1);
    access("R5 read read-only", 1, 32'h10, 2'd0);
    // Execute-only code (R7)
    load(2, 16'h0029, 32'h0000_F000, 20'hFFFFF, 2'd2, 1'b1);
    access("R7 read exec-only", 2, 32'h0, 2'd0);
    access("R7 fetch exec-only", 2, 32'hFFFFF, 2'd2);
    // Not present invalidates a previously good slot (R8)
    load(0, 16'h0100, 32'h1234_0000, 20'h0FFFF, 2'd0, 1'b0);
    access("R8 after not-present", 0, 32'h0, 2'd0);
    n_rd = 0; n_loads = 0;
    for (int it = 0; it < 200; it++) begin
      int sg;
      sg = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) begin
        load(sg, 16'($urandom), $urandom, 20'($urandom_range(0, 32'hFFFFF)),
             2'($urandom_range(0, 3)), $urandom_range(0, 9) != 0);
      end else begin
        logic [31:0] off;
        case ($urandom_range(0, 3))
          0: off = {12'd0, m_lim[sg]};
          1: off = {12'd0, m_lim[sg]} + 32'd1;
          default: off = $urandom_range(0, 32'h000F_FFFF);
        endcase
        access("R5 random", sg, off, 2'($urandom_range(0, 2)));
      end
    end
    @(negedge clk);
    chk("R2 reads per load", n_rd, n_loads);
    finish_run();
  end
endmodule